// File: doc/BRIEF.md
# Byte/Word Switchable Memory Read Port

This block models the read side of the pin interface of a parallel non-volatile memory whose data bus can run either 16 bits wide or 8 bits wide. All pin inputs are sampled on a fast system clock: the active-low select, read strobe and write strobe, the width-select pin, the word address and data pin 15. The block looks up a 16-bit word in an internal array. It then drives the data pins and per-pin tri-state enables, or releases the pins.

In narrow (8-bit) mode, data pin 15 becomes an extra address input that sits below the lowest word-address bit. It picks which half of the addressed word is returned on pins 0 to 7, while pins 8 to 14 float. The array is loaded through a back-door write port that stands in for programming, which is out of scope. Every pin input passes through a two-flop synchroniser, and the outputs are registered once more.

Top module: `mem_read_port`

## Requirements
- R1: With the width-select pin at 1 (wide mode) and a read enabled, all 16 output enables are 1 and `pad_o` carries the full 16-bit word at `addr_i`.
- R2: With the width-select pin at 0 (narrow mode) and a read enabled, `pad_oe_o` equals 16'h00FF, so only pins 0 to 7 are driven.
- R3: In narrow mode, `pad_i[15]`=0 returns bits 7:0 of the addressed word on `pad_o[7:0]`, and `pad_i[15]`=1 returns bits 15:8 on `pad_o[7:0]`.
- R4: A read is enabled only while `sel_ni`=0, `rd_ni`=0 and `wr_ni`=1. Otherwise `pad_oe_o` is 0.
- R5: The output enable of pin 15 is never 1 while in narrow mode.
- R6: A change on any pin input is reflected on `pad_o`/`pad_oe_o` in the third system clock edge after it is applied, and not before.
- R7: While `rst_ni` is low and after reset, before any pin change reaches the outputs, `pad_oe_o` and `pad_o` are 0.
- R8: A back-door write of `bd_data_i` to `bd_addr_i` changes what later reads of that address return.
- R9: In wide mode, `pad_i` (including bit 15) has no effect on the outputs.
- R10: Every bit of `pad_o` whose output enable is 0 is driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Chip select pin, active low |
| rd_ni | input | 1 | Read strobe pin, active low |
| wr_ni | input | 1 | Write strobe pin, active low |
| wide_i | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| addr_i | input | ADDR_W | Word address pins |
| pad_i | input | 16 | Data pin input values (bit 15 is the half select in narrow mode) |
| pad_o | output | 16 | Data pin output values |
| pad_oe_o | output | 16 | Per-pin output enables |
| bd_we_i | input | 1 | Back-door array write strobe |
| bd_addr_i | input | ADDR_W | Back-door write address |
| bd_data_i | input | 16 | Back-door write data |

## Verification
The bench aims at the half select. A design that ignores `pad_i[15]` or swaps its sense returns the wrong byte in narrow mode, and one that still honours it in wide mode corrupts full-word reads. It drives each of the three strobes alone into its disabling state, which exposes a port that drives the bus during a write or while deselected. It also checks the exact third-edge latency and the enable pattern of pins 8 to 15 in narrow mode. A missing synchroniser stage then shows up as early data, and a leaked pin-15 enable shows up as a driven address pin.

// File: rtl/mem_read_port_pkg.sv
package mem_read_port_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned CTRL_W = 5;

  typedef struct packed {
    logic half_sel;
    logic wide;
    logic wr_n;
    logic rd_n;
    logic sel_n;
  } pin_ctrl_t;

  localparam pin_ctrl_t CTRL_IDLE = '{half_sel: 1'b0, wide: 1'b1, wr_n: 1'b1, rd_n: 1'b1, sel_n: 1'b1};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 8,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_V[b];
        s2_q <= RST_V[b];
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pad_driver.sv
module pad_driver
  import mem_read_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pin_ctrl_t         ctrl_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] pad_o,
  output logic [WORD_W-1:0] pad_oe_o
);
  logic              rd_en;
  logic [HALF_W-1:0] half;
  logic [WORD_W-1:0] oe_d, dat_d;

  assign rd_en = !ctrl_i.sel_n && !ctrl_i.rd_n && ctrl_i.wr_n;
  assign half  = ctrl_i.half_sel ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];

  always_comb begin
    oe_d  = '0;
    dat_d = '0;
    if (rd_en) begin
      if (ctrl_i.wide) begin
        oe_d  = '1;
        dat_d = word_i;
      end else begin
        oe_d[HALF_W-1:0]  = '1;
        dat_d[HALF_W-1:0] = half;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_oe_o <= '0;
      pad_o    <= '0;
    end else begin
      pad_oe_o <= oe_d;
      pad_o    <= dat_d;
    end
  end

  // R4: disabled read releases the bus on the next edge
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> (pad_oe_o == '0));
  // R5: pin 15 never driven when narrow
  p_no_pin15_narrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.wide |=> !pad_oe_o[WORD_W-1]);
  // R2: narrow read drives exactly the low half
  p_narrow_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !ctrl_i.wide) |=> (pad_oe_o == 16'h00FF));
  // R10: undriven pins carry zero
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o & ~pad_oe_o) == '0));
  // R1: enable pattern is one of the legal three
  p_oe_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o == '0) || (pad_oe_o == 16'h00FF) || (pad_oe_o == 16'hFFFF));
endmodule

// File: rtl/mem_read_port.sv
module mem_read_port
  import mem_read_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] pad_i,
  output logic [WORD_W-1:0] pad_o,
  output logic [WORD_W-1:0] pad_oe_o,
  input  logic              bd_we_i,
  input  logic [ADDR_W-1:0] bd_addr_i,
  input  logic [WORD_W-1:0] bd_data_i
);
  localparam int unsigned SYNC_W = ADDR_W + CTRL_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {CTRL_IDLE, {ADDR_W{1'b0}}};

  pin_ctrl_t         ctrl_raw, ctrl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [WORD_W-1:0] word;

  assign ctrl_raw = '{half_sel: pad_i[WORD_W-1], wide: wide_i, wr_n: wr_ni,
                      rd_n: rd_ni, sel_n: sel_ni};

  pin_sync #(.W(SYNC_W), .RST_V(SYNC_RST)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ctrl_raw, addr_i}),
    .q_o    ({ctrl_s, addr_s})
  );

  word_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) i_store (
    .clk_i   (clk_i),
    .we_i    (bd_we_i),
    .waddr_i (bd_addr_i),
    .wdata_i (bd_data_i),
    .raddr_i (addr_s),
    .rdata_o (word)
  );

  pad_driver i_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_s),
    .word_i   (word),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );
endmodule

// File: tb/test_mem_read_port.sv
module test_mem_read_port;
  localparam int AW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0;
  logic sel_n = 1, rd_n = 1, wr_n = 1, wide = 1;
  logic [AW-1:0] addr = '0, bd_addr = '0;
  logic [15:0] pad_in = '0, bd_data = '0, pad_o, pad_oe;
  logic bd_we = 0;
  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] model [1<<AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_read_port #(.ADDR_W(AW)) i_mem_read_port (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .wide_i(wide), .addr_i(addr), .pad_i(pad_in), .pad_o(pad_o), .pad_oe_o(pad_oe),
    .bd_we_i(bd_we), .bd_addr_i(bd_addr), .bd_data_i(bd_data));

  function automatic logic [15:0] init_word(int a);
    return 16'((a * 16'h9E37) ^ 16'h5A5A);
  endfunction

  function automatic logic [15:0] exp_oe(logic s, logic r, logic w, logic wd);
    if (s || r || !w) return 16'h0000;
    return wd ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_dat(logic s, logic r, logic w, logic wd,
                                          logic [AW-1:0] a, logic hs);
    if (s || r || !w) return 16'h0000;
    if (wd) return model[a];
    return {8'h00, hs ? model[a][15:8] : model[a][7:0]};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bd_write(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bd_we = 1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 0;
    model[a] = d;
  endtask

  task automatic drive(logic s, logic r, logic w, logic wd, logic [AW-1:0] a, logic [15:0] p);
    @(negedge clk);
    sel_n = s; rd_n = r; wr_n = w; wide = wd; addr = a; pad_in = p;
  endtask

  // apply, then sample after exactly the third edge
  task automatic read_chk(string req, logic s, logic r, logic w, logic wd,
                          logic [AW-1:0] a, logic [15:0] p);
    drive(s, r, w, wd, a, p);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, pad_oe, exp_oe(s, r, w, wd));
    check(req, pad_o, exp_dat(s, r, w, wd, a, p[15]));
    check("R5", 16'(pad_oe[15] && !wd), 16'h0);
    check("R10", pad_o & ~pad_oe, 16'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog got=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R7", pad_oe, 16'h0);
    check("R7", pad_o, 16'h0);
    rst_ni = 1;
    for (int a = 0; a < (1 << AW); a++) bd_write(AW'(a), init_word(a));
    check("R7", pad_oe, 16'h0);

    // R1 wide read
    read_chk("R1", 0, 0, 1, 1, 8'h12, 16'h0000);
    // R9 pad_i ignored in wide mode
    read_chk("R9", 0, 0, 1, 1, 8'h12, 16'hFFFF);
    // R2/R3 narrow low and high half
    read_chk("R3", 0, 0, 1, 0, 8'h34, 16'h0000);
    read_chk("R3", 0, 0, 1, 0, 8'h34, 16'h8000);
    read_chk("R2", 0, 0, 1, 0, 8'hFF, 16'h7FFF);
    // R4 each strobe disables alone
    read_chk("R4", 1, 0, 1, 1, 8'h05, 16'h0);
    read_chk("R4", 0, 1, 1, 1, 8'h05, 16'h0);
    read_chk("R4", 0, 0, 0, 1, 8'h05, 16'h0);
    read_chk("R4", 0, 0, 0, 0, 8'h05, 16'h8000);

    // R6 latency: after two edges the old value still shows
    read_chk("R6", 0, 0, 1, 1, 8'h40, 16'h0);
    drive(0, 0, 1, 1, 8'h41, 16'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6", pad_o, model[8'h40]);
    @(negedge clk);
    check("R6", pad_o, model[8'h41]);

    // R8 back-door rewrite
    bd_write(8'h77, 16'hBEEF);
    read_chk("R8", 0, 0, 1, 1, 8'h77, 16'h0);
    read_chk("R8", 0, 0, 1, 0, 8'h77, 16'h8000);

    for (int i = 0; i < 300; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      if (i % 7 == 0) bd_write(AW'($urandom), 16'($urandom));
      read_chk(c[3] ? "R1" : "R3", c[0] & c[1], c[1] & c[2], ~(c[0] & c[2]), c[3],
               AW'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule